// File: doc/BRIEF.md
# Instruction Decode and Next-PC Unit

This block sits at the front of a simple in-order core. It takes one 32-bit instruction word and the byte address it was fetched from. It cuts the word into its register-index, shift, immediate and target fields, and turns the opcode and function code into a small set of control outputs for the execute, memory and write-back stages. In the same combinational pass it works out the address of the next instruction.

The unit only understands the instruction set listed below. Anything else is flagged as illegal and leaves every side-effect output quiet. It decides conditional branches from an equality flag supplied by an outside register comparator, and it takes a jump-through-register target from an outside register read port. It never reads the register file, the ALU or memory itself. Less-than style branches are not decoded; software builds them from a set-less-than followed by an equality branch.

The word layout, from the top bit down, is opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shift[10:6] and function[5:0]. Immediate-form words hold a 16-bit constant in [15:0]. Jump-form words hold a 26-bit word target in [25:0].

Top module: `instr_decode_npc`

## Requirements
- R1: `rs_idx_o`, `rt_idx_o`, `rd_idx_o` and `shamt_o` equal instruction bits [25:21], [20:16], [15:11] and [10:6], whatever the opcode. `imm_ext_o` is bits [15:0] sign-extended to 32 bits.
- R2: With opcode 0, the function codes 32 (add), 34 (sub), 36 (and), 37 (or), 38 (xor), 39 (nor) and 42 (set-less-than) give `alu_op_o` 1, 2, 3, 4, 5, 6 and 7, with register write to rd and `wb_sel_o`=0 (ALU result).
- R3: Opcode 8 (add immediate) gives `alu_op_o`=1 and opcode 10 (set-less-than immediate) gives `alu_op_o`=7. Both set `alu_use_imm_o`, write rt, and use `wb_sel_o`=0.
- R4: Loads (opcode 32 byte, 33 half, 35 word) set `mem_read_o`, `alu_op_o`=1, `alu_use_imm_o`, write rt, and use `wb_sel_o`=1. Stores (opcode 40 byte, 41 half, 43 word) set `mem_write_o`, `alu_op_o`=1 and `alu_use_imm_o`, with no register write. `mem_size_o` is 0 for byte, 1 for half and 2 for word. The read and write strobes are never both high.
- R5: Opcode 4 (branch if equal) and opcode 5 (branch if not equal) compare against `ops_equal_i`. If taken, `next_pc_o` = PC+4 + (sign-extended immediate × 4). If not taken, it is PC+4. There is no register write and `alu_op_o`=0.
- R6: Opcode 2 (jump) gives `next_pc_o` = {(PC+4)[31:28], target[25:0], 2'b00}, with no register write.
- R7: Opcode 3 (jump and link) gives the same target as R6. It writes register 31 with `wb_sel_o`=2, and `link_value_o` is PC+4.
- R8: Opcode 0 with function 8 (jump through register) gives `next_pc_o` = `rs_value_i`, with no register write.
- R9: Any opcode or function code not listed sets `illegal_o`. It leaves `alu_op_o`, `alu_use_imm_o`, `mem_read_o`, `mem_write_o`, `mem_size_o`, `wb_sel_o`, `reg_write_o` and `reg_waddr_o` all at 0.
- R10: With opcode 0, function 24 (multiply) and 26 (divide) give `alu_op_o` 8 and 9 with no register write. Function 16 (copy from high) and 18 (copy from low) give 10 and 11 and write rd.
- R11: Every instruction that is not a branch or jump, illegal ones included, gives `next_pc_o` = PC+4, wrapping modulo 2^32.
- R12: When `reg_write_o` is low, `reg_waddr_o` is 0. Outputs with no role for the decoded instruction are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Byte address of the instruction |
| ops_equal_i | input | 1 | rs equals rt, from the register comparator |
| rs_value_i | input | 32 | Value of register rs, used as the register jump target |
| next_pc_o | output | 32 | Address of the next instruction |
| link_value_o | output | 32 | PC+4, the return address |
| rs_idx_o | output | 5 | rs field |
| rt_idx_o | output | 5 | rt field |
| rd_idx_o | output | 5 | rd field |
| shamt_o | output | 5 | Shift-amount field |
| imm_ext_o | output | 32 | Sign-extended immediate |
| alu_op_o | output | 4 | Operation code for the execute stage |
| alu_use_imm_o | output | 1 | Second operand is the immediate |
| mem_read_o | output | 1 | Load strobe |
| mem_write_o | output | 1 | Store strobe |
| mem_size_o | output | 2 | Access size: 0 byte, 1 half, 2 word |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 link |
| reg_write_o | output | 1 | Register write enable |
| reg_waddr_o | output | 5 | Register write address |
| illegal_o | output | 1 | Unrecognised instruction |

## Verification
The embedded assertions watch, every time the inputs change, that:
- illegal words stay free of side effects;
- the two memory strobes are exclusive;
- a link write always targets register 31;
- the next address stays word aligned for aligned fetches, except for register jumps;
- jumps stay inside the 256 MiB region of PC+4.

Only the bench's sweeps can show that each opcode and function code maps to its exact control values and that the branch arithmetic is correct. The sweeps cover offsets at both signed extremes, jumps whose region bits come from PC+4 rather than PC, and address wrap-around.

// File: rtl/idec_pkg.sv
package idec_pkg;

   typedef enum logic [3:0] {
      ALU_NONE = 4'd0,
      ALU_ADD  = 4'd1,
      ALU_SUB  = 4'd2,
      ALU_AND  = 4'd3,
      ALU_OR   = 4'd4,
      ALU_XOR  = 4'd5,
      ALU_NOR  = 4'd6,
      ALU_SLT  = 4'd7,
      ALU_MULT = 4'd8,
      ALU_DIV  = 4'd9,
      ALU_MFHI = 4'd10,
      ALU_MFLO = 4'd11
   } alu_op_e;

   typedef enum logic [1:0] {
      WB_ALU  = 2'd0,
      WB_MEM  = 2'd1,
      WB_LINK = 2'd2
   } wb_sel_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } mem_size_e;

   typedef enum logic [2:0] {
      FLOW_SEQ  = 3'd0,
      FLOW_BEQ  = 3'd1,
      FLOW_BNE  = 3'd2,
      FLOW_JUMP = 3'd3,
      FLOW_JREG = 3'd4
   } flow_e;

   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_RD   = 2'd1,
      DST_RT   = 2'd2,
      DST_LINK = 2'd3
   } dst_e;

   typedef struct packed {
      alu_op_e   alu_op;
      logic      use_imm;
      logic      mem_rd;
      logic      mem_wr;
      mem_size_e mem_size;
      wb_sel_e   wb_sel;
      dst_e      dst;
      flow_e     flow;
      logic      illegal;
   } ctrl_t;

   localparam int unsigned OPC_W = 6;
   localparam int unsigned FNC_W = 6;

   localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
   localparam logic [OPC_W-1:0] OPC_J       = 6'd2;
   localparam logic [OPC_W-1:0] OPC_JAL     = 6'd3;
   localparam logic [OPC_W-1:0] OPC_BEQ     = 6'd4;
   localparam logic [OPC_W-1:0] OPC_BNE     = 6'd5;
   localparam logic [OPC_W-1:0] OPC_ADDI    = 6'd8;
   localparam logic [OPC_W-1:0] OPC_SLTI    = 6'd10;
   localparam logic [OPC_W-1:0] OPC_LB      = 6'd32;
   localparam logic [OPC_W-1:0] OPC_LH      = 6'd33;
   localparam logic [OPC_W-1:0] OPC_LW      = 6'd35;
   localparam logic [OPC_W-1:0] OPC_SB      = 6'd40;
   localparam logic [OPC_W-1:0] OPC_SH      = 6'd41;
   localparam logic [OPC_W-1:0] OPC_SW      = 6'd43;

   localparam logic [FNC_W-1:0] FNC_JR   = 6'd8;
   localparam logic [FNC_W-1:0] FNC_MFHI = 6'd16;
   localparam logic [FNC_W-1:0] FNC_MFLO = 6'd18;
   localparam logic [FNC_W-1:0] FNC_MULT = 6'd24;
   localparam logic [FNC_W-1:0] FNC_DIV  = 6'd26;
   localparam logic [FNC_W-1:0] FNC_ADD  = 6'd32;
   localparam logic [FNC_W-1:0] FNC_SUB  = 6'd34;
   localparam logic [FNC_W-1:0] FNC_AND  = 6'd36;
   localparam logic [FNC_W-1:0] FNC_OR   = 6'd37;
   localparam logic [FNC_W-1:0] FNC_XOR  = 6'd38;
   localparam logic [FNC_W-1:0] FNC_NOR  = 6'd39;
   localparam logic [FNC_W-1:0] FNC_SLT  = 6'd42;

endpackage

// File: rtl/idec_fields.sv
module idec_fields
   import idec_pkg::*;
#(
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned RA_W    = 5,
   localparam int unsigned IMM_W  = INSTR_W - OPC_W - 2*RA_W,
   localparam int unsigned TGT_W  = INSTR_W - OPC_W
) (
   input  logic [INSTR_W-1:0] word_i,
   output logic [OPC_W-1:0]   opc_o,
   output logic [RA_W-1:0]    rs_o,
   output logic [RA_W-1:0]    rt_o,
   output logic [RA_W-1:0]    rd_o,
   output logic [RA_W-1:0]    sh_o,
   output logic [FNC_W-1:0]   fnc_o,
   output logic [IMM_W-1:0]   imm_o,
   output logic [TGT_W-1:0]   tgt_o
);
   localparam int unsigned RS_HI = INSTR_W - OPC_W - 1;
   localparam int unsigned RT_HI = RS_HI - RA_W;
   localparam int unsigned RD_HI = RT_HI - RA_W;
   localparam int unsigned SH_HI = RD_HI - RA_W;

   if (INSTR_W != OPC_W + 4*RA_W + FNC_W) begin : g_bad_layout
      $error("idec_fields: INSTR_W does not match the field layout");
   end

   assign opc_o = word_i[INSTR_W-1 -: OPC_W];
   assign rs_o  = word_i[RS_HI -: RA_W];
   assign rt_o  = word_i[RT_HI -: RA_W];
   assign rd_o  = word_i[RD_HI -: RA_W];
   assign sh_o  = word_i[SH_HI -: RA_W];
   assign fnc_o = word_i[FNC_W-1:0];
   assign imm_o = word_i[IMM_W-1:0];
   assign tgt_o = word_i[TGT_W-1:0];
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
   import idec_pkg::*;
#(
   parameter bit HAS_MULDIV = 1'b1
) (
   input  logic [OPC_W-1:0] opc_i,
   input  logic [FNC_W-1:0] fnc_i,
   output ctrl_t            ctrl_o
);
   logic md_en;

   if (HAS_MULDIV) begin : g_md_on
      assign md_en = 1'b1;
   end else begin : g_md_off
      assign md_en = 1'b0;
   end

   ctrl_t c;

   always_comb begin
      c          = '0;
      c.alu_op   = ALU_NONE;
      c.mem_size = SZ_BYTE;
      c.wb_sel   = WB_ALU;
      c.dst      = DST_NONE;
      c.flow     = FLOW_SEQ;
      case (opc_i)
         OPC_SPECIAL: begin
            case (fnc_i)
               FNC_ADD: begin c.alu_op = ALU_ADD; c.dst = DST_RD; end
               FNC_SUB: begin c.alu_op = ALU_SUB; c.dst = DST_RD; end
               FNC_AND: begin c.alu_op = ALU_AND; c.dst = DST_RD; end
               FNC_OR:  begin c.alu_op = ALU_OR;  c.dst = DST_RD; end
               FNC_XOR: begin c.alu_op = ALU_XOR; c.dst = DST_RD; end
               FNC_NOR: begin c.alu_op = ALU_NOR; c.dst = DST_RD; end
               FNC_SLT: begin c.alu_op = ALU_SLT; c.dst = DST_RD; end
               FNC_JR:  c.flow = FLOW_JREG;
               FNC_MULT: begin
                  if (md_en) c.alu_op = ALU_MULT;
                  else       c.illegal = 1'b1;
               end
               FNC_DIV: begin
                  if (md_en) c.alu_op = ALU_DIV;
                  else       c.illegal = 1'b1;
               end
               FNC_MFHI: begin
                  if (md_en) begin c.alu_op = ALU_MFHI; c.dst = DST_RD; end
                  else       c.illegal = 1'b1;
               end
               FNC_MFLO: begin
                  if (md_en) begin c.alu_op = ALU_MFLO; c.dst = DST_RD; end
                  else       c.illegal = 1'b1;
               end
               default: c.illegal = 1'b1;
            endcase
         end
         OPC_ADDI: begin c.alu_op = ALU_ADD; c.use_imm = 1'b1; c.dst = DST_RT; end
         OPC_SLTI: begin c.alu_op = ALU_SLT; c.use_imm = 1'b1; c.dst = DST_RT; end
         OPC_LB, OPC_LH, OPC_LW: begin
            c.alu_op   = ALU_ADD;
            c.use_imm  = 1'b1;
            c.mem_rd   = 1'b1;
            c.dst      = DST_RT;
            c.wb_sel   = WB_MEM;
            c.mem_size = (opc_i == OPC_LW) ? SZ_WORD :
                         (opc_i == OPC_LH) ? SZ_HALF : SZ_BYTE;
         end
         OPC_SB, OPC_SH, OPC_SW: begin
            c.alu_op   = ALU_ADD;
            c.use_imm  = 1'b1;
            c.mem_wr   = 1'b1;
            c.mem_size = (opc_i == OPC_SW) ? SZ_WORD :
                         (opc_i == OPC_SH) ? SZ_HALF : SZ_BYTE;
         end
         OPC_BEQ: c.flow = FLOW_BEQ;
         OPC_BNE: c.flow = FLOW_BNE;
         OPC_J:   c.flow = FLOW_JUMP;
         OPC_JAL: begin c.flow = FLOW_JUMP; c.dst = DST_LINK; c.wb_sel = WB_LINK; end
         default: c.illegal = 1'b1;
      endcase
   end

   assign ctrl_o = c;

   always_comb begin
      if (!$isunknown(ctrl_o)) begin
         a_r9_illegal_quiet: assert (!ctrl_o.illegal ||
            (ctrl_o.alu_op == ALU_NONE && !ctrl_o.mem_rd && !ctrl_o.mem_wr &&
             ctrl_o.dst == DST_NONE && ctrl_o.flow == FLOW_SEQ))
            else $error("illegal word has side effects");
         a_r4_strobe_excl: assert (!(ctrl_o.mem_rd && ctrl_o.mem_wr))
            else $error("load and store strobes both high");
      end
   end
endmodule

// File: rtl/idec_npc.sv
module idec_npc
   import idec_pkg::*;
#(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IMM_W = 16,
   parameter int unsigned TGT_W = 26,
   localparam int unsigned OFF_W = IMM_W + 2,
   localparam int unsigned JMP_W = TGT_W + 2
) (
   input  flow_e            flow_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic             eq_i,
   input  logic [PC_W-1:0]  rs_val_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [TGT_W-1:0] tgt_i,
   output logic [PC_W-1:0]  pc_plus4_o,
   output logic [PC_W-1:0]  next_pc_o
);
   if (PC_W <= OFF_W) begin : g_bad_pc
      $error("idec_npc: PC_W must exceed the scaled branch offset width");
   end

   logic [PC_W-1:0] pc4;
   logic [PC_W-1:0] br_off;
   logic [PC_W-1:0] br_tgt;
   logic [PC_W-1:0] jmp_tgt;

   assign pc4    = pc_i + PC_W'(4);
   assign br_off = {{(PC_W-OFF_W){imm_i[IMM_W-1]}}, imm_i, 2'b00};
   assign br_tgt = pc4 + br_off;

   if (PC_W > JMP_W) begin : g_region
      assign jmp_tgt = {pc4[PC_W-1:JMP_W], tgt_i, 2'b00};
   end else begin : g_flat
      logic [JMP_W-1:0] full;
      assign full    = {tgt_i, 2'b00};
      assign jmp_tgt = full[PC_W-1:0];
   end

   always_comb begin
      case (flow_i)
         FLOW_BEQ:  next_pc_o = eq_i  ? br_tgt : pc4;
         FLOW_BNE:  next_pc_o = !eq_i ? br_tgt : pc4;
         FLOW_JUMP: next_pc_o = jmp_tgt;
         FLOW_JREG: next_pc_o = rs_val_i;
         default:   next_pc_o = pc4;
      endcase
   end

   assign pc_plus4_o = pc4;

   always_comb begin
      if (!$isunknown({flow_i, pc_i, next_pc_o})) begin
         a_r5_aligned: assert (flow_i == FLOW_JREG || pc_i[1:0] != 2'b00 ||
                               next_pc_o[1:0] == 2'b00)
            else $error("next PC lost word alignment");
      end
   end

   if (PC_W > JMP_W) begin : g_region_chk
      always_comb begin
         if (!$isunknown({flow_i, pc_i, next_pc_o})) begin
            a_r6_jump_region: assert (flow_i != FLOW_JUMP ||
               next_pc_o[PC_W-1:JMP_W] == pc_plus4_o[PC_W-1:JMP_W])
               else $error("jump left the PC+4 region");
         end
      end
   end
endmodule

// File: rtl/instr_decode_npc.sv
module instr_decode_npc
   import idec_pkg::*;
#(
   parameter int unsigned INSTR_W    = 32,
   parameter int unsigned RA_W       = 5,
   parameter int unsigned PC_W       = 32,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned LINK_REG   = 31,
   parameter bit          HAS_MULDIV = 1'b1,
   localparam int unsigned IMM_W     = INSTR_W - OPC_W - 2*RA_W,
   localparam int unsigned TGT_W     = INSTR_W - OPC_W
) (
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic               ops_equal_i,
   input  logic [PC_W-1:0]    rs_value_i,
   output logic [PC_W-1:0]    next_pc_o,
   output logic [PC_W-1:0]    link_value_o,
   output logic [RA_W-1:0]    rs_idx_o,
   output logic [RA_W-1:0]    rt_idx_o,
   output logic [RA_W-1:0]    rd_idx_o,
   output logic [RA_W-1:0]    shamt_o,
   output logic [DATA_W-1:0]  imm_ext_o,
   output logic [3:0]         alu_op_o,
   output logic               alu_use_imm_o,
   output logic               mem_read_o,
   output logic               mem_write_o,
   output logic [1:0]         mem_size_o,
   output logic [1:0]         wb_sel_o,
   output logic               reg_write_o,
   output logic [RA_W-1:0]    reg_waddr_o,
   output logic               illegal_o
);
   if (LINK_REG >= (1 << RA_W)) begin : g_bad_link
      $error("instr_decode_npc: LINK_REG out of register index range");
   end
   if (DATA_W <= IMM_W) begin : g_bad_data
      $error("instr_decode_npc: DATA_W must exceed the immediate width");
   end

   logic [OPC_W-1:0] opc;
   logic [FNC_W-1:0] fnc;
   logic [IMM_W-1:0] imm;
   logic [TGT_W-1:0] tgt;
   ctrl_t            ctrl;

   idec_fields #(.INSTR_W(INSTR_W), .RA_W(RA_W)) u_fields (
      .word_i (instr_i),
      .opc_o  (opc),
      .rs_o   (rs_idx_o),
      .rt_o   (rt_idx_o),
      .rd_o   (rd_idx_o),
      .sh_o   (shamt_o),
      .fnc_o  (fnc),
      .imm_o  (imm),
      .tgt_o  (tgt)
   );

   idec_ctrl #(.HAS_MULDIV(HAS_MULDIV)) u_ctrl (
      .opc_i  (opc),
      .fnc_i  (fnc),
      .ctrl_o (ctrl)
   );

   idec_npc #(.PC_W(PC_W), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_npc (
      .flow_i     (ctrl.flow),
      .pc_i       (pc_i),
      .eq_i       (ops_equal_i),
      .rs_val_i   (rs_value_i),
      .imm_i      (imm),
      .tgt_i      (tgt),
      .pc_plus4_o (link_value_o),
      .next_pc_o  (next_pc_o)
   );

   assign imm_ext_o     = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
   assign alu_op_o      = ctrl.alu_op;
   assign alu_use_imm_o = ctrl.use_imm;
   assign mem_read_o    = ctrl.mem_rd;
   assign mem_write_o   = ctrl.mem_wr;
   assign mem_size_o    = ctrl.mem_size;
   assign wb_sel_o      = ctrl.wb_sel;
   assign illegal_o     = ctrl.illegal;
   assign reg_write_o   = (ctrl.dst != DST_NONE);

   always_comb begin
      case (ctrl.dst)
         DST_RD:   reg_waddr_o = rd_idx_o;
         DST_RT:   reg_waddr_o = rt_idx_o;
         DST_LINK: reg_waddr_o = RA_W'(LINK_REG);
         default:  reg_waddr_o = '0;
      endcase
   end

   always_comb begin
      if (!$isunknown({wb_sel_o, reg_write_o, reg_waddr_o})) begin
         a_r7_link_target: assert (wb_sel_o != WB_LINK ||
                                   (reg_write_o && reg_waddr_o == RA_W'(LINK_REG)))
            else $error("link write not aimed at the link register");
         a_r12_idle_addr: assert (reg_write_o || reg_waddr_o == '0)
            else $error("write address nonzero without a write");
      end
   end
endmodule

// File: tb/instr_decode_npc_tb.sv
`timescale 1ns/1ps
module instr_decode_npc_tb;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [31:0] instr, pc, rsv;
   logic        eq;
   logic [31:0] npc, link, imm_ext;
   logic [4:0]  rs_i, rt_i, rd_i, sh, waddr;
   logic [3:0]  alu;
   logic        use_imm, mrd, mwr, we, ill;
   logic [1:0]  msz, wb;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   instr_decode_npc u_dut (
      .instr_i(instr), .pc_i(pc), .ops_equal_i(eq), .rs_value_i(rsv),
      .next_pc_o(npc), .link_value_o(link), .rs_idx_o(rs_i), .rt_idx_o(rt_i),
      .rd_idx_o(rd_i), .shamt_o(sh), .imm_ext_o(imm_ext), .alu_op_o(alu),
      .alu_use_imm_o(use_imm), .mem_read_o(mrd), .mem_write_o(mwr),
      .mem_size_o(msz), .wb_sel_o(wb), .reg_write_o(we), .reg_waddr_o(waddr),
      .illegal_o(ill)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h (instr %h pc %h)",
                  req, what, act, exp, instr, pc);
      end
   endtask

   task automatic run(input logic [31:0] w, input logic [31:0] p,
                      input logic e, input logic [31:0] r);
      logic [5:0]  op, fn;
      logic [31:0] pc4, sx, e_npc;
      logic [3:0]  e_alu;
      logic        e_imm, e_mrd, e_mwr, e_we, e_ill;
      logic [1:0]  e_sz, e_wb;
      logic [4:0]  e_wa;
      string       tag, ntag;
      @(posedge clk);
      instr = w; pc = p; eq = e; rsv = r;
      @(negedge clk);
      op = w[31:26]; fn = w[5:0];
      pc4 = p + 32'd4;
      sx = {{16{w[15]}}, w[15:0]};
      e_npc = pc4; e_alu = 0; e_imm = 0; e_mrd = 0; e_mwr = 0;
      e_we = 0; e_ill = 0; e_sz = 0; e_wb = 0; e_wa = 0;
      tag = "R9"; ntag = "R11";
      case (op)
         6'd0: begin
            tag = "R2";
            case (fn)
               6'd32: e_alu = 1;  6'd34: e_alu = 2;  6'd36: e_alu = 3;
               6'd37: e_alu = 4;  6'd38: e_alu = 5;  6'd39: e_alu = 6;
               6'd42: e_alu = 7;
               6'd24: begin e_alu = 8;  tag = "R10"; end
               6'd26: begin e_alu = 9;  tag = "R10"; end
               6'd16: begin e_alu = 10; tag = "R10"; end
               6'd18: begin e_alu = 11; tag = "R10"; end
               6'd8:  begin tag = "R8"; ntag = "R8"; e_npc = r; end
               default: begin e_ill = 1; tag = "R9"; end
            endcase
            if (!e_ill && fn != 6'd8 && fn != 6'd24 && fn != 6'd26) begin
               e_we = 1; e_wa = w[15:11];
            end
         end
         6'd8, 6'd10: begin
            tag = "R3"; e_alu = (op == 6'd8) ? 4'd1 : 4'd7;
            e_imm = 1; e_we = 1; e_wa = w[20:16];
         end
         6'd32, 6'd33, 6'd35: begin
            tag = "R4"; e_alu = 1; e_imm = 1; e_mrd = 1; e_we = 1;
            e_wa = w[20:16]; e_wb = 1;
            e_sz = (op == 6'd35) ? 2'd2 : (op == 6'd33) ? 2'd1 : 2'd0;
         end
         6'd40, 6'd41, 6'd43: begin
            tag = "R4"; e_alu = 1; e_imm = 1; e_mwr = 1;
            e_sz = (op == 6'd43) ? 2'd2 : (op == 6'd41) ? 2'd1 : 2'd0;
         end
         6'd4, 6'd5: begin
            tag = "R5"; ntag = "R5";
            if ((op == 6'd4) == e) e_npc = pc4 + (sx << 2);
         end
         6'd2: begin
            tag = "R6"; ntag = "R6";
            e_npc = {pc4[31:28], w[25:0], 2'b00};
         end
         6'd3: begin
            tag = "R7"; ntag = "R7";
            e_npc = {pc4[31:28], w[25:0], 2'b00};
            e_we = 1; e_wa = 5'd31; e_wb = 2;
         end
         default: e_ill = 1;
      endcase
      chk("R1", "fields", {rs_i, rt_i, rd_i, sh, imm_ext},
          {w[25:21], w[20:16], w[15:11], w[10:6], sx});
      chk(tag, "ctrl", {alu, use_imm, mrd, mwr, msz, wb, we, waddr, ill},
          {e_alu, e_imm, e_mrd, e_mwr, e_sz, e_wb, e_we, e_wa, e_ill});
      chk(ntag, "next_pc", npc, e_npc);
      if (op == 6'd3) chk("R7", "link", link, pc4);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      instr = '0; pc = '0; eq = 1'b0; rsv = '0;
      // Initial state: all-zero word is not decoded (R9), next is 4 (R11)
      run(32'h0000_0000, 32'h0, 1'b0, 32'h0);
      // Opcode sweep (R2..R9, R11)
      for (int o = 0; o < 64; o++)
         run({o[5:0], 5'd3, 5'd7, 16'h8005}, 32'h1000_0100, o[0], 32'h0BAD_0000);
      // Function sweep under opcode 0 (R2, R8, R9, R10, R12)
      for (int f = 0; f < 64; f++)
         run({6'd0, 5'd9, 5'd10, 5'd11, 5'd4, f[5:0]}, 32'h0040_1000, 1'b0,
             32'h1234_5678);
      // Branch offsets at the signed extremes (R5)
      for (int k = 0; k < 6; k++) begin
         logic [15:0] offs [6];
         offs = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234};
         for (int b = 0; b < 4; b++)
            run({(b[1] ? 6'd5 : 6'd4), 5'd1, 5'd2, offs[k]}, 32'h0040_0020,
                b[0], 32'h0);
      end
      // Jumps whose region differs between PC and PC+4 (R6, R7)
      run({6'd2, 26'h3FF_FFFF}, 32'hF000_0FFC, 1'b0, 32'h0);
      run({6'd2, 26'h000_0001}, 32'hEFFF_FFFC, 1'b0, 32'h0);
      run({6'd3, 26'h123_4567}, 32'hEFFF_FFFC, 1'b1, 32'h0);
      run({6'd3, 26'h000_0000}, 32'h0000_1000, 1'b0, 32'h0);
      // Register jump to an arbitrary value (R8)
      run({6'd0, 5'd31, 15'd0, 6'd8}, 32'h0000_2000, 1'b0, 32'hDEAD_BEE0);
      // Wrap-around of PC+4 for a plain instruction (R11)
      run({6'd0, 5'd1, 5'd2, 5'd3, 5'd0, 6'd32}, 32'hFFFF_FFFC, 1'b0, 32'h0);
      // Store leaves register write idle (R4, R12)
      run({6'd43, 5'd4, 5'd31, 16'h0010}, 32'h0000_0040, 1'b0, 32'h0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule